// File: doc/BRIEF.md
# Three-Level Latched Interrupt Aggregator

This block collects event pulses from several sub-blocks inside each line port and reduces them to one active-low interrupt pin. Every sub-block owns a sticky status register and a matching enable register. An enabled sticky bit raises that sub-block's bit in its port's summary. Any raised port summary sets that port's bit in the global summary, and a per-port mask register decides which ports may pull the pin low.

Software services the pin from the top down. It reads the global summary to pick a port, reads that port's summary to pick a sub-block, and reads the sticky register to find the event. It then writes ones to the sticky bits it has handled. The summary levels need no servicing: they follow the sticky and enable state in the same cycle.

Register access uses a plain single-cycle write strobe and a read strobe, with read data returned one cycle later. The number of ports, the sub-blocks per port and the status bits per sub-block are all parameters.

Top module: `irq_aggregator`

## Requirements
- R1: A synchronous active-low reset clears every sticky bit, every enable bit and every port mask bit, and `irq_n` reads high in the cycle after the reset edge.
- R2: An event input high at a clock edge sets its sticky bit. The bit stays set after the event input falls. Event bit `b` of sub-block `s` in port `p` is `evt_i[((p*NUM_SUBS)+s)*STAT_BITS + b]`.
- R3: Writing a sticky register clears exactly the bits written as 1. Bits written as 0 are unchanged. Nothing else clears a sticky bit.
- R4: When an event and a write-1 clear hit the same sticky bit in the same cycle, the bit stays set.
- R5: Enable registers read back what was written. A sticky bit whose enable bit is 0 affects neither the port summary nor `irq_n`.
- R6: Bit `s` of port `p`'s summary is 1 exactly when sub-block `s` has a set sticky bit with its enable set. Writes to a port summary address are ignored.
- R7: Bit `p` of the global summary is 1 exactly when port `p`'s summary is nonzero, whatever the mask. Writes to the global summary address are ignored.
- R8: `irq_n` is low exactly when some port has its global summary bit and its mask bit both set. It changes in the same cycle as the register that caused the change.
- R9: Port and global summary bits and `irq_n` return to inactive as soon as the causing sticky bits are cleared or their enables are removed.
- R10: The address map uses U = NUM_PORTS*NUM_SUBS. The sticky register of unit u = p*NUM_SUBS+s is at address 2u and its enable register is at 2u+1. Port summaries are at 2U+p, the global summary is at 2U+NUM_PORTS, and the port mask is at 2U+NUM_PORTS+1. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_PORTS*NUM_SUBS*STAT_BITS | Event inputs, one per sticky bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | STAT_BITS | Write data |
| bus_rdata | output | STAT_BITS | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A sticky bit that is wrongly lost or wrongly set shows up on the next read of its register, one cycle after the read strobe. If the bit is enabled and its port is unmasked, it also shows at `irq_n` in the very next cycle. A summary OR that is wired to the wrong port or sub-block shows as a bit in the wrong position when the summary registers are read back. A mask fault shows as `irq_n` going low while its port is masked, or staying high while it is unmasked, one cycle after the mask write.

// File: rtl/irq_agg_pkg.sv
// Shared types for the interrupt aggregator.
// Assumes no more than 256 ports or units, which the index width covers.
package irq_agg_pkg;

    localparam int IDX_W = 8;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STICKY,
        RK_ENABLE,
        RK_PORT_SUM,
        RK_GLOB_SUM,
        RK_GLOB_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] unit;
        logic [IDX_W-1:0] port;
    } reg_sel_t;

endpackage

// File: rtl/irq_addr_decode.sv
// Address decoder: turns a bus address into a register kind plus unit and port index.
// Assumes the flat map of the brief: sticky/enable pairs, then port summaries,
// then the global summary and the global mask.
module irq_addr_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SUBS  = 3,
    parameter int ADDR_W    = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int NUM_UNITS = NUM_PORTS * NUM_SUBS;
    localparam int PSUM_BASE = 2 * NUM_UNITS;
    localparam int GSUM_ADDR = PSUM_BASE + NUM_PORTS;
    localparam int GMSK_ADDR = GSUM_ADDR + 1;

    // Classify the address and derive indices arithmetically.
    always_comb begin
        int a;
        a        = int'(addr);
        sel.kind = RK_NONE;
        sel.unit = '0;
        sel.port = '0;
        if (a < PSUM_BASE) begin
            sel.kind = (a % 2 == 0) ? RK_STICKY : RK_ENABLE;
            sel.unit = IDX_W'(a / 2);
            sel.port = IDX_W'((a / 2) / NUM_SUBS);
        end else if (a < GSUM_ADDR) begin
            sel.kind = RK_PORT_SUM;
            sel.port = IDX_W'(a - PSUM_BASE);
        end else if (a == GSUM_ADDR) begin
            sel.kind = RK_GLOB_SUM;
        end else if (a == GMSK_ADDR) begin
            sel.kind = RK_GLOB_MASK;
        end
    end

endmodule

// File: rtl/irq_latch_bank.sv
// One sub-block's sticky status register and its enable register.
// Assumes clr_we and en_we are already qualified by the address decode.
// An event in the same cycle as a clear wins.
module irq_latch_bank #(
    parameter int STAT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STAT_BITS-1:0] evt,
    input  logic                 clr_we,
    input  logic                 en_we,
    input  logic [STAT_BITS-1:0] wdata,
    output logic [STAT_BITS-1:0] sticky_q,
    output logic [STAT_BITS-1:0] enable_q,
    output logic                 pending
);
    logic [STAT_BITS-1:0] clr_mask;

    // Clear mask is active only during a write to this sticky register.
    always_comb clr_mask = clr_we ? wdata : '0;

    // Sticky bits: keep the bits not cleared, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr_mask) | evt;
    end

    // Enable register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_q <= '0;
        else if (en_we) enable_q <= wdata;
    end

    // Sub-block request: any enabled sticky bit.
    always_comb pending = |(sticky_q & enable_q);

endmodule

// File: rtl/irq_summary.sv
// Port-level and global-level summaries.
// Assumes pending is ordered unit = port*NUM_SUBS + sub.
// The outputs are purely combinational, so they have no state to clear.
module irq_summary #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SUBS  = 3
) (
    input  logic [NUM_PORTS*NUM_SUBS-1:0] pending,
    output logic [NUM_PORTS*NUM_SUBS-1:0] port_sum,
    output logic [NUM_PORTS-1:0]          glob_sum
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Port summary: one bit per sub-block of port p.
        always_comb port_sum[p*NUM_SUBS +: NUM_SUBS] = pending[p*NUM_SUBS +: NUM_SUBS];
        // Global bit p: port p has any active sub-block.
        always_comb glob_sum[p] = |pending[p*NUM_SUBS +: NUM_SUBS];
    end

endmodule

// File: rtl/irq_global_mask.sv
// Global per-port mask register and the final active-low output.
// Assumes we is already qualified by the address decode.
module irq_global_mask #(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [NUM_PORTS-1:0] wdata,
    input  logic [NUM_PORTS-1:0] glob_sum,
    output logic [NUM_PORTS-1:0] mask_q,
    output logic                 irq_n
);
    // Mask register, cleared by reset so every port starts masked.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_q <= '0;
        else if (we) mask_q <= wdata;
    end

    // Pin is low when any unmasked port is active.
    always_comb irq_n = ~|(glob_sum & mask_q);

endmodule

// File: rtl/irq_aggregator.sv
// Top level of the three-level interrupt aggregator.
// Assumes STAT_BITS >= NUM_SUBS, STAT_BITS >= NUM_PORTS and
// 2**ADDR_W >= 2*NUM_PORTS*NUM_SUBS + NUM_PORTS + 2.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SUBS  = 3,
    parameter int STAT_BITS = 8,
    parameter int ADDR_W    = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS*NUM_SUBS*STAT_BITS-1:0] evt_i,
    input  logic                                  bus_wr,
    input  logic                                  bus_rd,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [STAT_BITS-1:0]                  bus_wdata,
    output logic [STAT_BITS-1:0]                  bus_rdata,
    output logic                                  bus_rvalid,
    output logic                                  irq_n
);
    localparam int NUM_UNITS = NUM_PORTS * NUM_SUBS;
    localparam int FLAT_W    = NUM_UNITS * STAT_BITS;

    reg_sel_t               sel;
    logic [FLAT_W-1:0]      sticky_all;
    logic [FLAT_W-1:0]      enable_all;
    logic [NUM_UNITS-1:0]   pending;
    logic [NUM_UNITS-1:0]   port_sum;
    logic [NUM_PORTS-1:0]   glob_sum;
    logic [NUM_PORTS-1:0]   glob_mask;
    logic                   mask_we;
    logic [STAT_BITS-1:0]   rd_mux;
    logic [STAT_BITS-1:0]   rdata_q;
    logic                   rvalid_q;

    irq_addr_decode #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_SUBS (NUM_SUBS),
        .ADDR_W   (ADDR_W)
    ) decode_i (
        .addr(bus_addr),
        .sel (sel)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic clr_we;
        logic en_we;

        // Write strobes for this unit's sticky and enable registers.
        always_comb begin
            clr_we = bus_wr && (sel.kind == RK_STICKY) && (sel.unit == IDX_W'(u));
            en_we  = bus_wr && (sel.kind == RK_ENABLE) && (sel.unit == IDX_W'(u));
        end

        irq_latch_bank #(
            .STAT_BITS(STAT_BITS)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_i[u*STAT_BITS +: STAT_BITS]),
            .clr_we  (clr_we),
            .en_we   (en_we),
            .wdata   (bus_wdata),
            .sticky_q(sticky_all[u*STAT_BITS +: STAT_BITS]),
            .enable_q(enable_all[u*STAT_BITS +: STAT_BITS]),
            .pending (pending[u])
        );
    end

    irq_summary #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_SUBS (NUM_SUBS)
    ) summary_i (
        .pending (pending),
        .port_sum(port_sum),
        .glob_sum(glob_sum)
    );

    // Mask write strobe; summary addresses get no strobe, so writes there are ignored.
    always_comb mask_we = bus_wr && (sel.kind == RK_GLOB_MASK);

    irq_global_mask #(
        .NUM_PORTS(NUM_PORTS)
    ) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mask_we),
        .wdata   (bus_wdata[NUM_PORTS-1:0]),
        .glob_sum(glob_sum),
        .mask_q  (glob_mask),
        .irq_n   (irq_n)
    );

    // Read multiplexer: zero-extended view of the selected register.
    always_comb begin
        rd_mux = '0;
        case (sel.kind)
            RK_STICKY: begin
                for (int u = 0; u < NUM_UNITS; u++)
                    if (int'(sel.unit) == u) rd_mux = sticky_all[u*STAT_BITS +: STAT_BITS];
            end
            RK_ENABLE: begin
                for (int u = 0; u < NUM_UNITS; u++)
                    if (int'(sel.unit) == u) rd_mux = enable_all[u*STAT_BITS +: STAT_BITS];
            end
            RK_PORT_SUM: begin
                for (int p = 0; p < NUM_PORTS; p++)
                    if (int'(sel.port) == p) rd_mux[NUM_SUBS-1:0] = port_sum[p*NUM_SUBS +: NUM_SUBS];
            end
            RK_GLOB_SUM:  rd_mux[NUM_PORTS-1:0] = glob_sum;
            RK_GLOB_MASK: rd_mux[NUM_PORTS-1:0] = glob_mask;
            default:      rd_mux = '0;
        endcase
    end

    // Registered read return: data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/irq_aggregator_chk.sv
// Assertion checker for irq_aggregator, attached by bind below.
// Assumes it sees the top's ports plus its flat sticky, enable and mask state.
module irq_aggregator_chk #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SUBS  = 3,
    parameter int STAT_BITS = 8
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic [NUM_PORTS*NUM_SUBS*STAT_BITS-1:0] evt_i,
    input logic                                    bus_wr,
    input logic                                    irq_n,
    input logic [NUM_PORTS*NUM_SUBS*STAT_BITS-1:0] sticky_all,
    input logic [NUM_PORTS*NUM_SUBS*STAT_BITS-1:0] enable_all,
    input logic [NUM_PORTS-1:0]                    glob_mask
);
    // R1: the cycle after a reset edge, the pin is inactive.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> irq_n);

    // R2 and R4: every event bit is set in the sticky register one edge later, even under a clear.
    assert_event_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((sticky_all & $past(evt_i)) == $past(evt_i)));

    // R3: without a write, no sticky bit drops.
    assert_sticky_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((sticky_all & $past(sticky_all)) == $past(sticky_all)));

    // R5: with no enabled sticky bit, the pin stays high.
    assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_all & enable_all) == '0) |-> irq_n);

    // R8: with every port masked, the pin stays high.
    assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_mask == '0) |-> irq_n);

    // R8: the pin falls only after an event or a register write.
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(bus_wr || (|evt_i)));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_SUBS (NUM_SUBS),
    .STAT_BITS(STAT_BITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .bus_wr    (bus_wr),
    .irq_n     (irq_n),
    .sticky_all(sticky_all),
    .enable_all(enable_all),
    .glob_mask (glob_mask)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares returns.
module irq_aggregator_tb_top;
    localparam int NP = 2;
    localparam int NS = 3;
    localparam int SB = 8;
    localparam int AW = 6;
    localparam int NU = NP * NS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NU*SB-1:0]  evt_i = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [SB-1:0]     bus_wdata = '0;
    logic [SB-1:0]     bus_rdata;
    logic              bus_rvalid;
    logic              irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [SB-1:0] exp;
        string         tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    irq_aggregator #(.NUM_PORTS(NP), .NUM_SUBS(NS), .STAT_BITS(SB), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_n(irq_n)
    );

    // Addresses from the map in R10.
    function automatic logic [AW-1:0] a_sticky(int p, int s); return AW'(2*(p*NS+s)); endfunction
    function automatic logic [AW-1:0] a_enable(int p, int s); return AW'(2*(p*NS+s)+1); endfunction
    function automatic logic [AW-1:0] a_psum(int p); return AW'(2*NU+p); endfunction
    localparam logic [AW-1:0] A_GSUM = AW'(2*NU+NP);
    localparam logic [AW-1:0] A_GMSK = AW'(2*NU+NP+1);
    function automatic int ebit(int p, int s, int b); return (p*NS+s)*SB+b; endfunction

    // Monitor: pops one expectation per returned read.
    always @(negedge clk) begin
        if (bus_rvalid) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read return: actual %h expected none", bus_rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic do_write(logic [AW-1:0] a, logic [SB-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(logic [AW-1:0] a, logic [SB-1:0] exp, string tag);
        exp_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(logic [NU*SB-1:0] v);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic check_irq(logic exp, string tag);
        checks++;
        if (irq_n !== exp) begin
            errors++;
            $display("FAIL %s irq_n: actual %b expected %b", tag, irq_n, exp);
        end
    endtask

    function automatic logic [NU*SB-1:0] one(int i);
        logic [NU*SB-1:0] v;
        v = '0; v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check_irq(1'b1, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        do_read(a_sticky(0, 1), 8'h00, "R1 sticky after reset");
        do_read(a_enable(0, 1), 8'h00, "R1 enable after reset");
        do_read(A_GMSK,        8'h00, "R1 mask after reset");

        // R2: event sets a bit that stays after the pulse.
        pulse(one(ebit(0, 1, 3)));
        @(negedge clk);
        do_read(a_sticky(0, 1), 8'h08, "R2 sticky holds");
        check_irq(1'b1, "R5 not enabled");
        do_read(a_psum(0), 8'h00, "R5 port summary disabled");

        // R5/R6/R7: enable it; summaries rise, mask still zero.
        do_write(a_enable(0, 1), 8'h08);
        do_read(a_enable(0, 1), 8'h08, "R5 enable readback");
        do_read(a_psum(0), 8'h02, "R6 port summary");
        do_read(A_GSUM,    8'h01, "R7 global summary masked");
        check_irq(1'b1, "R8 masked");

        // R8: the wrong port unmasked, then the right one.
        do_write(A_GMSK, 8'h02);
        check_irq(1'b1, "R8 other port unmasked");
        do_write(A_GMSK, 8'h01);
        check_irq(1'b0, "R8 port unmasked");

        // R6/R7: writes to summary addresses are ignored.
        do_write(a_psum(0), 8'h00);
        do_read(a_psum(0), 8'h02, "R6 summary read-only");
        do_write(A_GSUM, 8'h00);
        do_read(A_GSUM, 8'h01, "R7 global read-only");
        check_irq(1'b0, "R7 irq after ignored write");

        // R3: zeros leave bits alone; ones clear. R9: everything falls.
        do_write(a_sticky(0, 1), 8'h04);
        do_read(a_sticky(0, 1), 8'h08, "R3 zero bit kept");
        do_write(a_sticky(0, 1), 8'h08);
        check_irq(1'b1, "R9 irq after clear");
        do_read(a_sticky(0, 1), 8'h00, "R3 cleared");
        do_read(a_psum(0), 8'h00, "R9 port summary cleared");
        do_read(A_GSUM,    8'h00, "R9 global cleared");

        // R4: event and clear in the same cycle.
        evt_i = one(ebit(0, 1, 3));
        do_write(a_sticky(0, 1), 8'h08);
        evt_i = '0;
        do_read(a_sticky(0, 1), 8'h08, "R4 event wins");
        check_irq(1'b0, "R4 irq stays");

        // R9: removing the enable drops the summaries.
        do_write(a_enable(0, 1), 8'h00);
        check_irq(1'b1, "R9 irq after disable");
        do_read(a_psum(0), 8'h00, "R9 summary after disable");
        do_write(a_sticky(0, 1), 8'hFF);

        // Port 1 path, plus two bits in one sub-block of port 0.
        pulse(one(ebit(1, 2, 0)) | one(ebit(0, 0, 0)) | one(ebit(0, 0, 7)));
        do_read(a_sticky(0, 0), 8'h81, "R2 two bits");
        do_read(a_sticky(1, 2), 8'h01, "R2 port1 bit");
        do_write(a_enable(1, 2), 8'h01);
        do_write(A_GMSK, 8'h03);
        do_read(a_psum(1), 8'h04, "R6 port1 summary");
        do_read(A_GSUM,    8'h02, "R7 global port1");
        check_irq(1'b0, "R8 port1 active");
        do_write(A_GMSK, 8'h01);
        check_irq(1'b1, "R8 port1 masked");
        do_read(A_GMSK, 8'h01, "R8 mask readback");

        // R10: unmapped address reads zero.
        do_read(AW'(40), 8'h00, "R10 unmapped");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule